// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Access Arbiter

This block decides when a DRAM array gets refreshed and keeps refreshes and processor accesses apart. An interval timer clocked from the system clock raises a refresh request every 13 or 15 microseconds, whichever was chosen at programming. The block then either runs the refresh itself as soon as the memory is free, or, with automatic refresh inhibited, only reports the request and waits for an external start. Each refresh drives every RAS strobe low for a guaranteed minimum time that an extend input can stretch, and then enforces a precharge gap. The refresh row counter steps at the end of every refresh, and its value replaces the processor row address on the DRAM address bus while a refresh runs.

The first programming strobe after reset enables the block and opens an initialization window. During that window refreshes run back to back and no access is granted. Later programming strobes only change the interval. Separate inputs clear the row counter and restart the interval timer.

Top module: `rfsh_arbiter`

## Requirements
- R1: After programming, the interval timer raises `rfsh_pend` every 13×CLK_PER_US clocks when programmed with `prog_long`=0, or every 15×CLK_PER_US clocks with `prog_long`=1. The flag stays high until a refresh starts. Before the first programming no request is raised.
- R2: With `rfsh_inhibit` low, an idle controller that sees `rfsh_pend` starts a refresh on the next clock edge. `rfsh_busy` rises one cycle after the idle cycle in which the request was seen.
- R3: With `rfsh_inhibit` high, a pending request starts nothing and `rfsh_pend` stays high. A refresh starts from idle when `ext_rfsh_req` is high.
- R4: During a refresh, all `ras_n` bits are low for at least RAS_LOW cycles. While `rfsh_extend` is high the refresh is held. After the refresh, RAS_PRE precharge cycles pass before the controller returns to idle.
- R5: `rfsh_row` increments by one, modulo 2^ROW_W, on the edge that ends a refresh. `row_clr` forces it to zero, and this takes priority over the increment.
- R6: `dram_addr` equals `rfsh_row` while `rfsh_busy` is high and `cpu_row` otherwise.
- R7: The first `prog_stb` after reset sets `init_active` for INIT_CYCLES cycles. In that window refreshes run continuously and no access is granted. Later strobes change only the interval selection.
- R8: `acc_grant` and `rfsh_busy` are never high together. If an access and a refresh start are both possible in the same idle cycle, the refresh wins. A grant holds while `acc_req` stays high and drops the cycle after it falls.
- R9: `timer_clr` restarts the interval count from zero without changing `rfsh_pend`.
- R10: After reset the block is unprogrammed: no flags are set, all `ras_n` are high and `rfsh_row` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_stb | input | 1 | Programming strobe |
| prog_long | input | 1 | Interval select taken at programming: 0 = 13 us, 1 = 15 us |
| rfsh_inhibit | input | 1 | Suppresses automatic refresh |
| ext_rfsh_req | input | 1 | External refresh start |
| rfsh_extend | input | 1 | Holds the running refresh |
| row_clr | input | 1 | Clears the refresh row counter |
| timer_clr | input | 1 | Restarts the interval timer |
| acc_req | input | 1 | Processor access request |
| cpu_row | input | ROW_W | Processor row address |
| rfsh_pend | output | 1 | Refresh interval has elapsed |
| rfsh_busy | output | 1 | Refresh in progress |
| acc_grant | output | 1 | Access owns the memory |
| init_active | output | 1 | Initialization window open |
| ras_n | output | NUM_RAS | Row strobes, active low |
| rfsh_row | output | ROW_W | Refresh row counter |
| dram_addr | output | ROW_W | Multiplexed DRAM row address |

## Verification
Every registered result is due one clock after the edge that samples its cause. `rfsh_pend` appears on the edge after the count reaches its end, and `rfsh_busy` or `acc_grant` in the cycle after the deciding idle cycle. The row counter changes on the edge that leaves a refresh. `dram_addr` follows `cpu_row` or the counter in the same cycle. The bench advances its behavioural model on each rising edge from the inputs held since the previous falling edge. It compares every output shortly after the falling edge, so each result is checked exactly in the cycle the requirements place it.

// File: rtl/rfsh_arbiter.sv
module rfsh_arbiter #(
  parameter int CLK_PER_US  = 4,
  parameter int INIT_CYCLES = 200,
  parameter int RAS_LOW     = 3,
  parameter int RAS_PRE     = 2,
  parameter int ROW_W       = 4,
  parameter int NUM_RAS     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_stb,
  input  logic               prog_long,
  input  logic               rfsh_inhibit,
  input  logic               ext_rfsh_req,
  input  logic               rfsh_extend,
  input  logic               row_clr,
  input  logic               timer_clr,
  input  logic               acc_req,
  input  logic [ROW_W-1:0]   cpu_row,
  output logic               rfsh_pend,
  output logic               rfsh_busy,
  output logic               acc_grant,
  output logic               init_active,
  output logic [NUM_RAS-1:0] ras_n,
  output logic [ROW_W-1:0]   rfsh_row,
  output logic [ROW_W-1:0]   dram_addr
);
  localparam int PER_S = 13 * CLK_PER_US;
  localparam int PER_L = 15 * CLK_PER_US;
  localparam int TW    = $clog2(PER_L + 1);
  localparam int IW    = $clog2(INIT_CYCLES + 1);
  localparam int PMAX  = (RAS_LOW > RAS_PRE) ? RAS_LOW : RAS_PRE;
  localparam int CW    = $clog2(PMAX + 1);
  localparam logic [TW-1:0] END_S   = TW'(PER_S - 1);
  localparam logic [TW-1:0] END_L   = TW'(PER_L - 1);
  localparam logic [IW-1:0] INIT_END = IW'(INIT_CYCLES - 1);
  localparam logic [CW-1:0] LOW_END = CW'(RAS_LOW - 1);
  localparam logic [CW-1:0] PRE_END = CW'(RAS_PRE - 1);

  typedef enum logic [1:0] {S_IDLE, S_RFSH, S_PRE, S_ACC} st_t;

  st_t           st;
  logic          armed, mode_long;
  logic [TW-1:0] tmr;
  logic [IW-1:0] icnt;
  logic [CW-1:0] pcnt;
  logic          expire, start, rf_done;

  assign expire  = armed && !timer_clr && (tmr >= (mode_long ? END_L : END_S));
  assign start   = (st == S_IDLE) && armed &&
                   ((rfsh_pend && !rfsh_inhibit) || ext_rfsh_req || init_active);
  assign rf_done = (st == S_RFSH) && (pcnt >= LOW_END) && !rfsh_extend;

  assign rfsh_busy = (st == S_RFSH);
  assign acc_grant = (st == S_ACC);
  assign ras_n     = rfsh_busy ? '0 : '1;
  assign dram_addr = rfsh_busy ? rfsh_row : cpu_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed       <= 1'b0;
      mode_long   <= 1'b0;
      init_active <= 1'b0;
      icnt        <= '0;
    end else begin
      if (prog_stb) begin
        mode_long <= prog_long;
        if (!armed) begin
          armed       <= 1'b1;
          init_active <= 1'b1;
          icnt        <= '0;
        end
      end
      if (init_active) begin
        if (icnt >= INIT_END) init_active <= 1'b0;
        else                  icnt        <= icnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr       <= '0;
      rfsh_pend <= 1'b0;
    end else begin
      if (!armed || timer_clr || expire) tmr <= '0;
      else                               tmr <= tmr + 1'b1;
      if (expire)     rfsh_pend <= 1'b1;
      else if (start) rfsh_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      pcnt <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          pcnt <= '0;
          if (start)                              st <= S_RFSH;
          else if (acc_req && armed && !init_active) st <= S_ACC;
        end
        S_RFSH: begin
          if (rf_done) begin
            st   <= S_PRE;
            pcnt <= '0;
          end else if (pcnt < LOW_END) begin
            pcnt <= pcnt + 1'b1;
          end
        end
        S_PRE: begin
          if (pcnt >= PRE_END) st <= S_IDLE;
          else                 pcnt <= pcnt + 1'b1;
        end
        S_ACC: if (!acc_req) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rfsh_row <= '0;
    else if (row_clr) rfsh_row <= '0;
    else if (rf_done) rfsh_row <= rfsh_row + 1'b1;
  end
endmodule

// File: rtl/rfsh_arbiter_chk.sv
module rfsh_arbiter_chk #(
  parameter int ROW_W   = 4,
  parameter int RAS_LOW = 3,
  parameter int RAS_PRE = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rfsh_busy,
  input logic             acc_grant,
  input logic             rfsh_extend,
  input logic             rfsh_inhibit,
  input logic             ext_rfsh_req,
  input logic             init_active,
  input logic             row_clr,
  input logic [ROW_W-1:0] rfsh_row
);
  logic [7:0] run, gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0;
      gap <= 8'(RAS_PRE);
    end else begin
      run <= !rfsh_busy ? 8'd0 : (run == 8'hFF ? run : run + 8'd1);
      gap <= rfsh_busy ? 8'd0 : (gap == 8'hFF ? gap : gap + 8'd1);
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(rfsh_busy && acc_grant)); // R8

  AST_RAS_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rfsh_busy) |-> run >= 8'(RAS_LOW)); // R4

  AST_EXTEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_busy && rfsh_extend |=> rfsh_busy); // R4

  AST_PRECHARGE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rfsh_busy) || $rose(acc_grant)) |-> gap >= 8'(RAS_PRE)); // R4

  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rfsh_busy) |-> ($past(ext_rfsh_req) || !$past(rfsh_inhibit) || $past(init_active))); // R3

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rfsh_busy) && !$past(row_clr) |-> rfsh_row == ROW_W'($past(rfsh_row) + 1'b1)); // R5
endmodule

bind rfsh_arbiter rfsh_arbiter_chk #(.ROW_W(ROW_W), .RAS_LOW(RAS_LOW), .RAS_PRE(RAS_PRE)) u_chk (
  .clk(clk), .rst_n(rst_n), .rfsh_busy(rfsh_busy), .acc_grant(acc_grant),
  .rfsh_extend(rfsh_extend), .rfsh_inhibit(rfsh_inhibit), .ext_rfsh_req(ext_rfsh_req),
  .init_active(init_active), .row_clr(row_clr), .rfsh_row(rfsh_row));

// File: tb/rfsh_arbiter_test.sv
module rfsh_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPU = 4, INIT = 200, RLOW = 3, RPRE = 2, RW = 4, NR = 4;

  logic clk = 0, rst_n = 0;
  logic prog_stb = 0, prog_long = 0, rfsh_inhibit = 0, ext_rfsh_req = 0;
  logic rfsh_extend = 0, row_clr = 0, timer_clr = 0, acc_req = 0;
  logic [RW-1:0] cpu_row = '0;
  logic rfsh_pend, rfsh_busy, acc_grant, init_active;
  logic [NR-1:0] ras_n;
  logic [RW-1:0] rfsh_row, dram_addr;

  int checks = 0, fails = 0;
  bit done = 0;

  rfsh_arbiter #(.CLK_PER_US(CPU), .INIT_CYCLES(INIT), .RAS_LOW(RLOW),
                 .RAS_PRE(RPRE), .ROW_W(RW), .NUM_RAS(NR)) uut (
    .clk(clk), .rst_n(rst_n), .prog_stb(prog_stb), .prog_long(prog_long),
    .rfsh_inhibit(rfsh_inhibit), .ext_rfsh_req(ext_rfsh_req), .rfsh_extend(rfsh_extend),
    .row_clr(row_clr), .timer_clr(timer_clr), .acc_req(acc_req), .cpu_row(cpu_row),
    .rfsh_pend(rfsh_pend), .rfsh_busy(rfsh_busy), .acc_grant(acc_grant),
    .init_active(init_active), .ras_n(ras_n), .rfsh_row(rfsh_row), .dram_addr(dram_addr));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: phase 0 idle, 1 refresh, 2 precharge, 3 access
  bit m_prog, m_long, m_pend, m_init;
  int m_tmr, m_icnt, m_phase, m_cnt, m_row;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prog = 0; m_long = 0; m_pend = 0; m_init = 0;
      m_tmr = 0; m_icnt = 0; m_phase = 0; m_cnt = 0; m_row = 0;
    end else begin
      int period;
      bit exp_now, go, leave;
      period  = (m_long ? 15 : 13) * CPU;
      exp_now = m_prog && !timer_clr && (m_tmr >= period - 1);
      go      = (m_phase == 0) && m_prog && ((m_pend && !rfsh_inhibit) || ext_rfsh_req || m_init);
      leave   = (m_phase == 1) && (m_cnt + 1 >= RLOW) && !rfsh_extend;
      if (row_clr) m_row = 0;
      else if (leave) m_row = (m_row + 1) % (1 << RW);
      if (!m_prog || timer_clr || exp_now) m_tmr = 0; else m_tmr++;
      if (exp_now) m_pend = 1; else if (go) m_pend = 0;
      case (m_phase)
        0: if (go) begin m_phase = 1; m_cnt = 0; end
           else if (acc_req && m_prog && !m_init) m_phase = 3;
        1: if (leave) begin m_phase = 2; m_cnt = 0; end else m_cnt++;
        2: if (m_cnt + 1 >= RPRE) m_phase = 0; else m_cnt++;
        default: if (!acc_req) m_phase = 0;
      endcase
      if (m_init) begin
        if (m_icnt >= INIT - 1) m_init = 0; else m_icnt++;
      end
      if (prog_stb) begin
        m_long = prog_long;
        if (!m_prog) begin m_prog = 1; m_init = 1; m_icnt = 0; end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R1 rfsh_pend", rfsh_pend, m_pend);
      chk("R2 rfsh_busy", rfsh_busy, m_phase == 1);
      chk("R4 ras_n", ras_n, (m_phase == 1) ? 0 : (1 << NR) - 1);
      chk("R5 rfsh_row", rfsh_row, m_row);
      chk("R6 dram_addr", dram_addr, (m_phase == 1) ? m_row : cpu_row);
      chk("R7 init_active", init_active, m_init);
      chk("R8 acc_grant", acc_grant, m_phase == 3);
    end
  end

  task automatic run(int n, int acc_pct, int ext_pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cpu_row     = RW'($urandom);
      acc_req     = ($urandom % 100) < acc_pct;
      rfsh_extend = ($urandom % 100) < ext_pct;
      row_clr     = 0; timer_clr = 0; prog_stb = 0; ext_rfsh_req = 0;
    end
  endtask

  task automatic summary();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    repeat (14000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 pend", rfsh_pend, 0);
    chk("R10 busy", rfsh_busy, 0);
    chk("R10 grant", acc_grant, 0);
    chk("R10 ras_n", ras_n, (1 << NR) - 1);
    chk("R10 row", rfsh_row, 0);
    rst_n = 1;
    run(20, 60, 0);               // R8 no grant before programming
    @(negedge clk); prog_stb = 1; prog_long = 0; acc_req = 1;
    run(260, 50, 10);             // R7 init burst with access attempts
    run(400, 40, 0);              // R1 short interval, R8 contention
    @(negedge clk); prog_stb = 1; prog_long = 1;
    run(400, 30, 20);             // R1 long interval, R4 extend
    @(negedge clk); timer_clr = 1;
    run(30, 0, 0);                // R9
    @(negedge clk); row_clr = 1;
    run(5, 0, 0);                 // R5 clear
    rfsh_inhibit = 1;
    run(150, 20, 0);
    chk("R3 pend held while inhibited", rfsh_pend, 1);
    chk("R3 no refresh while inhibited", rfsh_busy, 0);
    @(negedge clk); acc_req = 0; ext_rfsh_req = 1;
    run(20, 0, 30);               // R3 external start
    rfsh_inhibit = 0;
    run(300, 70, 10);
    summary();
  end
endmodule